// File: doc/BRIEF.md
# Flash Status Register and Write-Protect Unit

This unit keeps the eight-bit status register of a serial NOR flash slave and rules on every array write request. A command front end, which does the serial shifting and opcode decode, hands it single-cycle events. These events are: write enable and write disable, the status-write arming instruction, a status write with its data byte, completion of a program or erase, the end of an automatic-increment programming run, any other completed instruction, and a chip-select rise that arrives before a full command byte. The unit also samples the active-low write-protect pin and the busy flag of the operation engine.

A program or erase request carries an operation code and a 21-bit byte address. One clock later the unit returns a grant strobe with an allow or deny verdict. A three-bit zone code in the register selects a protected region that grows downward from the top of the array, in 64 KB blocks. A lock bit, together with the pin held low, freezes the protection fields.

Top module: `flash_wp_status`

## Requirements
- R1: After reset the status byte reads 0x1C: zone code 111, and lock, auto-increment and write-enable bits 0. No grant strobe is active.
- R2: The status byte is laid out as follows. Bit 0 is busy and copies `busy_in` with no delay. Bit 1 is write enable. Bits 4:2 are the zone code. Bit 5 always reads 0. Bit 6 is the auto-increment flag. Bit 7 is the lock bit.
- R3: `ev_wren` sets write enable. `ev_wrdi` clears it, and so does `ev_done` (completion of a program or erase).
- R4: A status write takes effect only if the previous event was `ev_wren` or `ev_ewsr`. Any of `ev_wrdi`, `ev_other`, `ev_abort`, `ev_done`, `ev_aai_exit`, `ev_wrsr` or `req_valid` disarms it.
- R5: A status write that takes effect loads the zone code from data bits 4:2 and the lock bit from data bit 7. It clears write enable and leaves the other bits unchanged.
- R6: While `wp_n` is low and the lock bit is 1, status writes are ignored completely, and write enable is kept. While `wp_n` is high, status writes execute and may clear the lock bit. While `wp_n` is low and the lock bit is 0, a status write may set the lock bit.
- R7: The zone code selects how many of the top 64 KB blocks are protected. Code 0 protects none. Codes 1 to 5 protect 1, 2, 4, 8 or 16 blocks. Codes 6 and 7 protect all 32 blocks.
- R8: A request is allowed only when write enable is 1, the operation code is valid, and the target block lies outside the protected region. The operation codes are 0 for byte program, 1 for auto-increment program, 2 for sector erase, 3 for block erase and 4 for chip erase. Codes 5 to 7 are always denied.
- R9: A chip erase request (code 4) is denied unless the zone code is 000.
- R10: `grant_valid` pulses exactly one clock after `req_valid`, and `grant_ok` carries the verdict. A denied request changes no status bit.
- R11: An allowed auto-increment request (code 1) sets bit 6. `ev_aai_exit` clears bit 6 and write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_wren | input | 1 | Write-enable instruction completed |
| ev_wrdi | input | 1 | Write-disable instruction completed |
| ev_ewsr | input | 1 | Status-write arming instruction completed |
| ev_wrsr | input | 1 | Status write completed |
| wrsr_data | input | 8 | Data byte of the status write |
| ev_other | input | 1 | Any other instruction completed |
| ev_abort | input | 1 | Chip select rose before a full command byte |
| ev_done | input | 1 | Program or erase operation finished |
| ev_aai_exit | input | 1 | Auto-increment programming ended |
| wp_n | input | 1 | Write-protect pin, active low |
| busy_in | input | 1 | Busy flag from the operation engine |
| req_valid | input | 1 | Program or erase request strobe |
| req_op | input | 3 | Request operation code |
| req_addr | input | 21 | Request target byte address |
| grant_valid | output | 1 | Verdict strobe, one clock after the request |
| grant_ok | output | 1 | 1 = request allowed |
| status_byte | output | 8 | Status register as read by the host |
| wel | output | 1 | Write enable |
| busy | output | 1 | Busy bit |

## Verification
On every cycle the embedded assertions check the following. The lock bit never falls while the pin is low. A status write that is locked or not armed leaves the protection fields stable. A request made without write enable, and a chip erase with a non-zero zone, always come back denied. Every request is followed by its grant strobe, and an auto-increment exit clears its flag and write enable. Some behaviours only the directed scenarios can show: the exact region boundary for each zone code, that each kind of intervening event disarms a status write, and the exact byte values produced by field loading and by denied requests.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

   typedef enum logic [2:0] {
      OP_BYTE_PGM   = 3'd0,
      OP_AAI_PGM    = 3'd1,
      OP_SECT_ERASE = 3'd2,
      OP_BLK_ERASE  = 3'd3,
      OP_CHIP_ERASE = 3'd4
   } wr_op_e;

   localparam int SR_W       = 8;
   localparam int ZONE_W     = 3;
   localparam int POS_BUSY   = 0;
   localparam int POS_WEL    = 1;
   localparam int POS_ZONE   = 2;
   localparam int POS_AAI    = 6;
   localparam int POS_LOCK   = 7;

   localparam logic [ZONE_W-1:0] ZONE_RESET = '1;

endpackage

// File: rtl/fsr_zone_check.sv
module fsr_zone_check #(
   parameter int ADDR_W  = 21,
   parameter int BLOCK_W = 16
) (
   input  logic [2:0]        zone,
   input  logic              is_chip,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam int IDX_W   = ADDR_W - BLOCK_W;
   localparam int NUM_BLK = 1 << IDX_W;

   generate
      if (IDX_W < 1) begin : g_bad_geometry
         $error("fsr_zone_check: ADDR_W must exceed BLOCK_W");
      end
   endgenerate

   logic [IDX_W:0]   prot_cnt;
   logic [IDX_W:0]   first_blk;
   logic [IDX_W-1:0] blk_idx;

   // protected block count doubles with each code step, clamped to the whole array
   always_comb begin
      if (zone == 3'd0)
         prot_cnt = '0;
      else if (zone >= 3'd6 || (32'(zone) - 32'd1) >= 32'(IDX_W))
         prot_cnt = (IDX_W+1)'(NUM_BLK);
      else
         prot_cnt = (IDX_W+1)'(1) << (zone - 3'd1);
   end

   assign first_blk = (IDX_W+1)'(NUM_BLK) - prot_cnt;
   assign blk_idx   = addr[ADDR_W-1:BLOCK_W];
   assign hit       = is_chip ? (zone != 3'd0) : ({1'b0, blk_idx} >= first_blk);

endmodule

// File: rtl/fsr_arm_ctrl.sv
module fsr_arm_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_set,
   input  logic arm_kill,
   input  logic wrsr_ev,
   input  logic wp_n,
   input  logic lock,
   output logic armed,
   output logic wrsr_take
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed <= 1'b0;
      else if (arm_set)
         armed <= 1'b1;
      else if (arm_kill || wrsr_ev)
         armed <= 1'b0;
   end

   assign wrsr_take = wrsr_ev && armed && (wp_n || !lock);

endmodule

// File: rtl/flash_wp_status.sv
module flash_wp_status
   import flash_sr_pkg::*;
#(
   parameter int ADDR_W  = 21,
   parameter int BLOCK_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_wren,
   input  logic              ev_wrdi,
   input  logic              ev_ewsr,
   input  logic              ev_wrsr,
   input  logic [7:0]        wrsr_data,
   input  logic              ev_other,
   input  logic              ev_abort,
   input  logic              ev_done,
   input  logic              ev_aai_exit,
   input  logic              wp_n,
   input  logic              busy_in,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              grant_valid,
   output logic              grant_ok,
   output logic [7:0]        status_byte,
   output logic              wel,
   output logic              busy
);
   logic              wel_q, aai_q, lock_q;
   logic [ZONE_W-1:0] zone_q;
   logic              armed, wrsr_take, zone_hit, op_known, req_ok, arm_kill;
   wr_op_e            op_e;
   logic              unused_data;

   assign unused_data = ^{wrsr_data[6:5], wrsr_data[1:0]};
   assign op_e        = wr_op_e'(req_op);
   assign op_known    = (req_op <= 3'd4);
   assign arm_kill    = ev_wrdi | ev_other | ev_abort | ev_done | ev_aai_exit | req_valid;

   fsr_arm_ctrl u_arm (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm_set   (ev_wren | ev_ewsr),
      .arm_kill  (arm_kill),
      .wrsr_ev   (ev_wrsr),
      .wp_n      (wp_n),
      .lock      (lock_q),
      .armed     (armed),
      .wrsr_take (wrsr_take)
   );

   fsr_zone_check #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) u_zone (
      .zone    (zone_q),
      .is_chip (op_e == OP_CHIP_ERASE),
      .addr    (req_addr),
      .hit     (zone_hit)
   );

   assign req_ok = req_valid && wel_q && op_known && !zone_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q  <= 1'b0;
         aai_q  <= 1'b0;
         lock_q <= 1'b0;
         zone_q <= ZONE_RESET;
      end else begin
         if (wrsr_take || ev_wrdi || ev_done || ev_aai_exit)
            wel_q <= 1'b0;
         else if (ev_wren)
            wel_q <= 1'b1;

         if (ev_aai_exit)
            aai_q <= 1'b0;
         else if (req_ok && op_e == OP_AAI_PGM)
            aai_q <= 1'b1;

         if (wrsr_take) begin
            zone_q <= wrsr_data[POS_ZONE +: ZONE_W];
            lock_q <= wrsr_data[POS_LOCK];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_valid <= 1'b0;
         grant_ok    <= 1'b0;
      end else begin
         grant_valid <= req_valid;
         grant_ok    <= req_ok;
      end
   end

   always_comb begin
      status_byte                        = '0;
      status_byte[POS_BUSY]              = busy_in;
      status_byte[POS_WEL]               = wel_q;
      status_byte[POS_ZONE +: ZONE_W]    = zone_q;
      status_byte[POS_AAI]               = aai_q;
      status_byte[POS_LOCK]              = lock_q;
   end

   assign wel  = wel_q;
   assign busy = busy_in;

   // R6: lock bit cannot fall while the pin is low
   assert_lock_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && !wp_n) |=> lock_q);

   // R6: a locked status write leaves the protection fields alone
   assert_locked_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_wrsr && lock_q && !wp_n) |=> ($stable(zone_q) && $stable(lock_q)));

   // R4: an unarmed status write changes nothing
   assert_unarmed_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_wrsr && !armed) |=> ($stable(zone_q) && $stable(lock_q)));

   // R5: an executed status write drops write enable
   assert_write_clears_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_wrsr && armed && wp_n) |=> !wel_q);

   // R8: without write enable every request is denied
   assert_no_wel_deny_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !wel_q) |=> (grant_valid && !grant_ok));

   // R9: chip erase needs an empty zone
   assert_chip_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd4 && zone_q != 3'd0) |=> !grant_ok);

   // R10: every request yields a strobe on the next cycle
   assert_grant_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> grant_valid);

   // R11: leaving auto-increment clears the flag and write enable
   assert_aai_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ev_aai_exit |=> (!aai_q && !wel_q));

endmodule

// File: tb/tb_flash_wp_status.sv
module tb_flash_wp_status;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_wren = 0, ev_wrdi = 0, ev_ewsr = 0, ev_wrsr = 0;
   logic        ev_other = 0, ev_abort = 0, ev_done = 0, ev_aai_exit = 0;
   logic [7:0]  wrsr_data = '0;
   logic        wp_n = 1'b1, busy_in = 1'b0, req_valid = 1'b0;
   logic [2:0]  req_op = '0;
   logic [20:0] req_addr = '0;
   logic        grant_valid, grant_ok, wel, busy;
   logic [7:0]  status_byte;

   int checks = 0;
   int fails  = 0;
   bit done_flag = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_wp_status dut (
      .clk(clk), .rst_n(rst_n),
      .ev_wren(ev_wren), .ev_wrdi(ev_wrdi), .ev_ewsr(ev_ewsr), .ev_wrsr(ev_wrsr),
      .wrsr_data(wrsr_data), .ev_other(ev_other), .ev_abort(ev_abort),
      .ev_done(ev_done), .ev_aai_exit(ev_aai_exit), .wp_n(wp_n), .busy_in(busy_in),
      .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
      .grant_valid(grant_valid), .grant_ok(grant_ok), .status_byte(status_byte),
      .wel(wel), .busy(busy)
   );

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
      end
   endtask

   // event codes: 0 wren 1 wrdi 2 ewsr 3 wrsr 4 other 5 abort 6 done 7 aai_exit
   task automatic ev(input int k, input logic [7:0] d = 8'h00);
      @(negedge clk);
      wrsr_data = d;
      case (k)
         0: ev_wren = 1;      1: ev_wrdi = 1;
         2: ev_ewsr = 1;      3: ev_wrsr = 1;
         4: ev_other = 1;     5: ev_abort = 1;
         6: ev_done = 1;      default: ev_aai_exit = 1;
      endcase
      @(negedge clk);
      {ev_wren, ev_wrdi, ev_ewsr, ev_wrsr, ev_other, ev_abort, ev_done, ev_aai_exit} = '0;
   endtask

   task automatic request(input logic [2:0] op, input logic [20:0] a, output logic ok);
      @(negedge clk);
      req_valid = 1; req_op = op; req_addr = a;
      chk("R10 no strobe in request cycle", grant_valid, 0);
      @(negedge clk);
      req_valid = 0;
      chk("R10 strobe one clock later", grant_valid, 1);
      ok = grant_ok;
      @(negedge clk);
      chk("R10 strobe lasts one clock", grant_valid, 0);
   endtask

   task automatic set_status(input logic [7:0] d);
      wp_n = 1;
      ev(0);
      ev(3, d);
   endtask

   function automatic logic [21:0] prot_start(input int code);
      if (code == 0) return 22'h200000;
      if (code >= 6) return 22'h0;
      return 22'((32 - (1 << (code - 1))) << 16);
   endfunction

   task automatic t_reset;
      chk("R1 reset status", status_byte, 8'h1C);
      chk("R1 reset wel", wel, 0);
      chk("R1 reset grant", grant_valid, 0);
   endtask

   task automatic t_layout;
      @(negedge clk); busy_in = 1; #1;
      chk("R2 busy bit", status_byte[0], 1);
      chk("R2 busy port", busy, 1);
      chk("R2 reserved bit", status_byte[5], 0);
      busy_in = 0; #1;
      chk("R2 busy clears", status_byte, 8'h1C);
   endtask

   task automatic t_wel;
      ev(0); chk("R3 wren sets", status_byte, 8'h1E);
      ev(1); chk("R3 wrdi clears", wel, 0);
      ev(0); ev(6); chk("R3 done clears", wel, 0);
   endtask

   task automatic t_arm;
      ev(0); ev(4); ev(3, 8'h00);
      chk("R4 other disarms", status_byte[7:2], 6'h07);
      ev(2); ev(5); ev(3, 8'h00);
      chk("R4 abort disarms", status_byte[7:2], 6'h07);
      ev(1);
      ev(2); ev(3, 8'h00);
      chk("R4 ewsr arms", status_byte, 8'h00);
   endtask

   task automatic t_fields;
      wp_n = 1;
      ev(2); ev(3, 8'hFF);
      chk("R5 only zone and lock written", status_byte, 8'h9C);
      ev(0); ev(3, 8'h00);
      chk("R5 write clears wel", status_byte, 8'h00);
   endtask

   task automatic t_lock;
      set_status(8'h88);
      chk("R6 lock set with pin high", status_byte, 8'h88);
      wp_n = 0;
      ev(0); ev(3, 8'h00);
      chk("R6 locked write ignored", status_byte, 8'h8A);
      ev(1);
      wp_n = 1;
      ev(2); ev(3, 8'h00);
      chk("R6 pin high clears lock", status_byte, 8'h00);
      wp_n = 0;
      ev(0); ev(3, 8'h84);
      chk("R6 lock set with pin low", status_byte, 8'h84);
      wp_n = 1;
      set_status(8'h00);
   endtask

   task automatic t_region;
      logic ok;
      for (int c = 0; c < 8; c++) begin
         logic [21:0] b;
         set_status(8'(c << 2));
         ev(0);
         b = prot_start(c);
         if (b != 0) begin
            request(3'd0, 21'(b - 1), ok);
            chk($sformatf("R7 code %0d below boundary allowed", c), ok, 1);
         end
         if (b != 22'h200000) begin
            request(3'd2, b[20:0], ok);
            chk($sformatf("R7 code %0d at boundary denied", c), ok, 0);
         end
         ev(1);
      end
      set_status(8'h00);
   endtask

   task automatic t_need_wel;
      logic ok;
      request(3'd3, 21'h000100, ok);
      chk("R8 no wel denied", ok, 0);
      ev(0);
      request(3'd5, 21'h000100, ok);
      chk("R8 unknown op denied", ok, 0);
      request(3'd3, 21'h000100, ok);
      chk("R8 block erase allowed", ok, 1);
      ev(6);
   endtask

   task automatic t_chip;
      logic ok;
      set_status(8'h04);
      ev(0);
      request(3'd4, 21'h0, ok);
      chk("R9 chip erase with zone denied", ok, 0);
      chk("R10 denial leaves status", status_byte, 8'h06);
      ev(1);
      set_status(8'h00); ev(0);
      request(3'd4, 21'h0, ok);
      chk("R9 chip erase zone zero allowed", ok, 1);
      ev(6);
   endtask

   task automatic t_aai;
      logic ok;
      request(3'd1, 21'h000010, ok);
      chk("R11 denied aai no flag", status_byte, 8'h00);
      ev(0);
      request(3'd1, 21'h000010, ok);
      chk("R11 aai allowed", ok, 1);
      chk("R11 aai flag set", status_byte, 8'h42);
      ev(7);
      chk("R11 exit clears flag and wel", status_byte, 8'h00);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done_flag) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1;
      @(negedge clk);
      t_reset;
      t_layout;
      t_wel;
      t_arm;
      t_fields;
      t_lock;
      t_region;
      t_need_wel;
      t_chip;
      t_aai;
      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule